// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block watches a decoded SDRAM command stream, one command per clock. It keeps a model of each bank: whether a row is open, which row that is, whether an automatic precharge is queued, and whether a precharge recovery interval is still running. Each incoming command is tested against that model and against the global spacing rules. A command that breaks a rule is reported on a registered error pulse with a code that names the rule. It is not applied to the model.

The checker sits beside a memory controller during verification or silicon debug. It needs the command code, the bank bits and the row/column address bus. The recovery interval after precharge and the spacing after a mode load are parameters counted in clock cycles. The burst length comes from each mode-register load, so automatic precharge lands on the correct cycle.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A mode load (code 1) or extended mode load (code 2) is legal only when no bank is open or busy; otherwise the error code is 2. A legal mode load (code 1) stores the burst length from address bits 2:0: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and any other value gives 1. An extended mode load leaves the burst length unchanged.
- R2: After a legal mode or extended mode load at cycle t, any defined command other than NOP (code 0) issued before cycle t+T_MRD gets error code 1. This rule takes priority over every other rule.
- R3: An activate (code 3) to a bank that is idle and not busy opens that bank. The row from address bits 11:0 then appears on `open_row_o[ba*12 +: 12]`.
- R4: An activate to a bank that already has an open row gets error code 3.
- R5: A read (code 4) or write (code 5) to a bank that is idle and not busy gets error code 4.
- R6: A precharge (code 6) with address bit 10 low closes only the addressed bank. With bit 10 high it closes every open bank and ignores the bank bits. A precharge to an idle, non-busy bank is legal and has no effect.
- R7: After a precharge at cycle t, the closed bank shows busy and accepts a new command from cycle t+T_RP onward. Before that, activate, read, write or precharge aimed at it gets error code 5. An all-bank precharge while any bank is busy also gets code 5.
- R8: A read or write with address bit 10 high, under burst length n, marks the bank busy from the next cycle. The bank then closes by itself, and an activate to it is accepted from cycle t+n+T_RP. An earlier activate gets code 5.
- R9: When the burst length is full page, address bit 10 on a read or write is ignored: the bank stays open and not busy.
- R10: An auto refresh (code 8) while any bank is open or busy gets error code 6.
- R11: A burst terminate (code 7) is legal only while a burst is live. For length n, a burst is live during the n-1 cycles after the read or write. A full-page burst stays live until a burst terminate or a precharge. A legal burst terminate ends the burst. Otherwise the error code is 7.
- R12: `err_o` is high for exactly the cycle after the offending command, with `err_code_o` naming the rule; both are 0 otherwise. A rejected command changes no bank state. Codes 9 to 15 act as NOP.
- R13: Synchronous reset leaves all banks idle and not busy, all timers expired, the burst length at 1 and the error outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 4 | Command code |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Row / column / option address |
| err_o | output | 1 | One-cycle rule violation pulse |
| err_code_o | output | 3 | Code of the violated rule |
| bank_open_o | output | 4 | Per-bank row-open flag |
| bank_busy_o | output | 4 | Per-bank precharge or automatic-precharge pending flag |
| open_row_o | output | 48 | Open row of each bank, 12 bits per bank |

## Verification
The bench builds the checker with four banks, 12-bit rows, T_RP of 3 and T_MRD of 2. These values are small enough that every spacing window can be probed one cycle before and exactly on its boundary in a few cycles. T_MRD of 2 leaves room for one rejected command inside the window. The bench programs burst lengths of 4 and full page, which places the automatic-precharge close at cycle t+4+3. It also exercises both the finite-burst and the open-ended burst-terminate windows.

// File: rtl/sdchk_pkg.sv
package sdchk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_MODE  = 4'd1,
        CMD_EMODE = 4'd2,
        CMD_ACT   = 4'd3,
        CMD_RD    = 4'd4,
        CMD_WR    = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_BST   = 4'd7,
        CMD_REF   = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_MRD       = 3'd1,
        ERR_MODE_BUSY = 3'd2,
        ERR_ACT_OPEN  = 3'd3,
        ERR_ACC_IDLE  = 3'd4,
        ERR_BANK_BUSY = 3'd5,
        ERR_REF_BUSY  = 3'd6,
        ERR_BST_NONE  = 3'd7
    } err_e;

    localparam int BL_MAX = 8;

    typedef struct packed {
        logic       full;
        logic [3:0] beats;
    } blen_t;

    typedef struct packed {
        logic act;
        logic acc;
        logic ap;
        logic pre_one;
        logic pre_all;
        logic mode;
        logic setbl;
        logic bst;
    } go_t;

    function automatic blen_t decode_blen(input logic [2:0] code);
        blen_t b;
        b.full = 1'b0;
        case (code)
            3'd1:    b.beats = 4'd2;
            3'd2:    b.beats = 4'd4;
            3'd3:    b.beats = 4'd8;
            3'd7:    begin b.beats = 4'd1; b.full = 1'b1; end
            default: b.beats = 4'd1;
        endcase
        return b;
    endfunction

    function automatic cmd_e to_cmd(input logic [3:0] raw);
        cmd_e c;
        case (raw)
            4'd1:    c = CMD_MODE;
            4'd2:    c = CMD_EMODE;
            4'd3:    c = CMD_ACT;
            4'd4:    c = CMD_RD;
            4'd5:    c = CMD_WR;
            4'd6:    c = CMD_PRE;
            4'd7:    c = CMD_BST;
            4'd8:    c = CMD_REF;
            default: c = CMD_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sdchk_rules.sv
module sdchk_rules
    import sdchk_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BA_W = $clog2(NBANK)
) (
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic              a10,
    input  logic [NBANK-1:0]  bank_open,
    input  logic [NBANK-1:0]  bank_busy,
    input  logic              mrd_wait,
    input  logic              burst_live,
    output err_e              err,
    output go_t               go
);
    logic sel_open;
    logic sel_busy;
    logic any_active;

    always_comb begin
        sel_open   = bank_open[ba];
        sel_busy   = bank_busy[ba];
        any_active = (|bank_open) || (|bank_busy);
        err        = ERR_NONE;
        go         = '0;
        if (cmd != CMD_NOP && mrd_wait) begin
            err = ERR_MRD;
        end else begin
            case (cmd)
                CMD_MODE, CMD_EMODE: begin
                    if (any_active) err = ERR_MODE_BUSY;
                    else begin
                        go.mode  = 1'b1;
                        go.setbl = (cmd == CMD_MODE);
                    end
                end
                CMD_ACT: begin
                    if (sel_busy)      err = ERR_BANK_BUSY;
                    else if (sel_open) err = ERR_ACT_OPEN;
                    else               go.act = 1'b1;
                end
                CMD_RD, CMD_WR: begin
                    if (sel_busy)       err = ERR_BANK_BUSY;
                    else if (!sel_open) err = ERR_ACC_IDLE;
                    else begin
                        go.acc = 1'b1;
                        go.ap  = a10;
                    end
                end
                CMD_PRE: begin
                    if (a10) begin
                        if (|bank_busy) err = ERR_BANK_BUSY;
                        else            go.pre_all = 1'b1;
                    end else begin
                        if (sel_busy)   err = ERR_BANK_BUSY;
                        else            go.pre_one = 1'b1;
                    end
                end
                CMD_BST: begin
                    if (!burst_live) err = ERR_BST_NONE;
                    else             go.bst = 1'b1;
                end
                CMD_REF: begin
                    if (any_active) err = ERR_REF_BUSY;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdchk_spacing.sv
module sdchk_spacing
    import sdchk_pkg::*;
#(
    parameter int T_MRD = 2,
    parameter int CNT_W = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_go,
    input  logic  acc_go,
    input  logic  bst_go,
    input  logic  pre_go,
    input  blen_t bl,
    output logic  mrd_wait,
    output logic  burst_live
);
    logic [CNT_W-1:0] mrd_cnt;
    logic [CNT_W-1:0] beat_cnt;
    logic             full_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            mrd_cnt <= '0;
        end else if (mode_go) begin
            mrd_cnt <= CNT_W'(T_MRD - 1);
        end else if (mrd_cnt != '0) begin
            mrd_cnt <= mrd_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_cnt  <= '0;
            full_live <= 1'b0;
        end else if (acc_go) begin
            full_live <= bl.full;
            beat_cnt  <= bl.full ? '0 : CNT_W'(bl.beats - 4'd1);
        end else if (bst_go) begin
            full_live <= 1'b0;
            beat_cnt  <= '0;
        end else begin
            if (pre_go) full_live <= 1'b0;
            if (beat_cnt != '0) beat_cnt <= beat_cnt - 1'b1;
        end
    end

    assign mrd_wait   = (mrd_cnt != '0);
    assign burst_live = (beat_cnt != '0) || full_live;

    generate
        if (T_MRD > 1) begin : g_mrd_chk
            assert_mrd_window_R2: assert property (@(posedge clk) disable iff (rst)
                mode_go |=> mrd_wait);
        end
    endgenerate

    assert_bst_ends_R11: assert property (@(posedge clk) disable iff (rst)
        bst_go |=> !burst_live);

endmodule

// File: rtl/sdchk_bank.sv
module sdchk_bank #(
    parameter int ROW_W = 12,
    parameter int CNT_W = 4,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_go,
    input  logic             acc_go,
    input  logic             ap_req,
    input  logic [CNT_W-1:0] beats,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic             busy_o,
    output logic [ROW_W-1:0] row_o
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] rp_cnt;
    logic [CNT_W-1:0] ap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rp_cnt <= '0;
            ap_cnt <= '0;
        end else begin
            if (rp_cnt != '0) rp_cnt <= rp_cnt - 1'b1;
            if (ap_cnt != '0) begin
                if (ap_cnt == CNT_W'(1)) begin
                    open_q <= 1'b0;
                    rp_cnt <= CNT_W'(T_RP - 1);
                end
                ap_cnt <= ap_cnt - 1'b1;
            end
            if (act_go) begin
                open_q <= 1'b1;
                row_q  <= row_in;
            end
            if (acc_go && ap_req) ap_cnt <= beats;
            if (pre_go && open_q) begin
                open_q <= 1'b0;
                rp_cnt <= CNT_W'(T_RP - 1);
            end
        end
    end

    assign open_o = open_q;
    assign busy_o = (rp_cnt != '0) || (ap_cnt != '0);
    assign row_o  = row_q;

    assert_act_idle_R4: assert property (@(posedge clk) disable iff (rst)
        act_go |-> !open_q);

    assert_acc_open_R5: assert property (@(posedge clk) disable iff (rst)
        acc_go |-> (open_q && !busy_o));

    assert_row_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !act_go |=> $stable(row_q));

    generate
        if (T_RP > 1) begin : g_ap_chk
            assert_ap_close_R8: assert property (@(posedge clk) disable iff (rst)
                (ap_cnt == CNT_W'(1)) |=> (!open_q && busy_o));
        end
    endgenerate

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdchk_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int ROW_W = 12,
    parameter int T_RP  = 3,
    parameter int T_MRD = 2,
    localparam int BA_W = $clog2(NBANK),
    localparam int T_BIG = (T_RP > T_MRD) ? T_RP : T_MRD,
    localparam int T_ALL = (T_BIG > BL_MAX) ? T_BIG : BL_MAX,
    localparam int CNT_W = $clog2(T_ALL + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             cmd_i,
    input  logic [BA_W-1:0]        ba_i,
    input  logic [ROW_W-1:0]       addr_i,
    output logic                   err_o,
    output logic [2:0]             err_code_o,
    output logic [NBANK-1:0]       bank_open_o,
    output logic [NBANK-1:0]       bank_busy_o,
    output logic [NBANK*ROW_W-1:0] open_row_o
);
    cmd_e  cmd;
    err_e  rule_err;
    err_e  err_q;
    go_t   go;
    blen_t bl_q;
    logic  mrd_wait;
    logic  burst_live;
    logic  pre_any;

    assign cmd     = to_cmd(cmd_i);
    assign pre_any = go.pre_one || go.pre_all;

    sdchk_rules #(.NBANK(NBANK)) u_rules (
        .cmd        (cmd),
        .ba         (ba_i),
        .a10        (addr_i[10]),
        .bank_open  (bank_open_o),
        .bank_busy  (bank_busy_o),
        .mrd_wait   (mrd_wait),
        .burst_live (burst_live),
        .err        (rule_err),
        .go         (go)
    );

    sdchk_spacing #(.T_MRD(T_MRD), .CNT_W(CNT_W)) u_spacing (
        .clk        (clk),
        .rst        (rst),
        .mode_go    (go.mode),
        .acc_go     (go.acc),
        .bst_go     (go.bst),
        .pre_go     (pre_any),
        .bl         (bl_q),
        .mrd_wait   (mrd_wait),
        .burst_live (burst_live)
    );

    generate
        for (genvar i = 0; i < NBANK; i++) begin : g_bank
            logic here;
            assign here = (ba_i == BA_W'(i));
            sdchk_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W), .T_RP(T_RP)) u_bank (
                .clk    (clk),
                .rst    (rst),
                .act_go (go.act && here),
                .acc_go (go.acc && here),
                .ap_req (go.ap && !bl_q.full),
                .beats  (CNT_W'(bl_q.beats)),
                .pre_go ((go.pre_one && here) || go.pre_all),
                .row_in (addr_i),
                .open_o (bank_open_o[i]),
                .busy_o (bank_busy_o[i]),
                .row_o  (open_row_o[i*ROW_W +: ROW_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bl_q  <= '{full: 1'b0, beats: 4'd1};
            err_q <= ERR_NONE;
        end else begin
            err_q <= rule_err;
            if (go.setbl) bl_q <= decode_blen(addr_i[2:0]);
        end
    end

    assign err_o      = (err_q != ERR_NONE);
    assign err_code_o = err_q;

    assert_reject_keeps_rows_R12: assert property (@(posedge clk) disable iff (rst)
        (rule_err != ERR_NONE) |=> $stable(open_row_o));

    assert_pre_all_closes_R6: assert property (@(posedge clk) disable iff (rst)
        go.pre_all |=> (bank_open_o == '0));

    assert_mode_idle_R1: assert property (@(posedge clk) disable iff (rst)
        go.mode |=> (bank_open_o == '0));

endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;
    localparam logic [3:0] C_NOP = 4'd0, C_MODE = 4'd1, C_ACT = 4'd3,
                           C_RD = 4'd4, C_WR = 4'd5, C_PRE = 4'd6,
                           C_BST = 4'd7, C_REF = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cmd_i = 4'd0;
    logic [1:0]  ba_i = 2'd0;
    logic [11:0] addr_i = 12'd0;
    logic        err_o;
    logic [2:0]  err_code_o;
    logic [3:0]  bank_open_o;
    logic [3:0]  bank_busy_o;
    logic [47:0] open_row_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_checker #(.NBANK(4), .ROW_W(12), .T_RP(3), .T_MRD(2)) dut (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .ba_i(ba_i), .addr_i(addr_i),
        .err_o(err_o), .err_code_o(err_code_o), .bank_open_o(bank_open_o),
        .bank_busy_o(bank_busy_o), .open_row_o(open_row_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
        @(negedge clk);
        cmd_i  = c;
        ba_i   = b;
        addr_i = a;
        @(posedge clk);
        #1;
        cmd_i  = C_NOP;
    endtask

    task automatic expect_err(input int exp, input string tag);
        check(err_code_o == 3'(exp) && err_o == (exp != 0), tag, "error code",
              int'(err_code_o), exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 2'd0, 12'd0);
    endtask

    task automatic t_reset;
        check(bank_open_o == 4'd0, "R13", "open after reset", int'(bank_open_o), 0);
        check(bank_busy_o == 4'd0, "R13", "busy after reset", int'(bank_busy_o), 0);
        check(err_o == 1'b0, "R13", "err after reset", int'(err_o), 0);
    endtask

    task automatic t_open_access;
        issue(C_ACT, 2'd1, 12'h5A3); expect_err(0, "R3");
        check(bank_open_o[1], "R3", "bank1 open", int'(bank_open_o[1]), 1);
        check(open_row_o[12 +: 12] == 12'h5A3, "R3", "row", int'(open_row_o[12 +: 12]), 'h5A3);
        issue(C_ACT, 2'd1, 12'h111); expect_err(3, "R4");
        check(open_row_o[12 +: 12] == 12'h5A3, "R12", "row kept on reject",
              int'(open_row_o[12 +: 12]), 'h5A3);
        idle(1);
        check(err_o == 1'b0, "R12", "pulse one cycle", int'(err_o), 0);
        issue(C_RD, 2'd2, 12'h000); expect_err(4, "R5");
        issue(C_WR, 2'd1, 12'h000); expect_err(0, "R5");
        check(bank_open_o[1], "R5", "still open after write", int'(bank_open_o[1]), 1);
        issue(4'hC, 2'd1, 12'h000); expect_err(0, "R12");
    endtask

    task automatic t_precharge;
        issue(C_PRE, 2'd1, 12'h000); expect_err(0, "R6");
        check(!bank_open_o[1] && bank_busy_o[1], "R7", "bank1 closed+busy",
              int'({bank_open_o[1], bank_busy_o[1]}), 1);
        issue(C_ACT, 2'd1, 12'h0F0); expect_err(5, "R7");
        idle(1);
        issue(C_ACT, 2'd1, 12'h0F0); expect_err(0, "R7");
        issue(C_ACT, 2'd0, 12'h001); expect_err(0, "R3");
        issue(C_PRE, 2'd3, 12'h400); expect_err(0, "R6");
        check(bank_open_o == 4'd0, "R6", "all closed", int'(bank_open_o), 0);
        check(bank_busy_o == 4'b0011, "R6", "busy set", int'(bank_busy_o), 3);
        issue(C_PRE, 2'd2, 12'h000); expect_err(0, "R6");
        issue(C_PRE, 2'd0, 12'h400); expect_err(5, "R7");
        idle(2);
    endtask

    task automatic t_mode;
        issue(C_ACT, 2'd0, 12'h002); expect_err(0, "R3");
        issue(C_MODE, 2'd0, 12'h002); expect_err(2, "R1");
        issue(C_PRE, 2'd0, 12'h000); expect_err(0, "R6");
        idle(2);
        issue(C_MODE, 2'd0, 12'h002); expect_err(0, "R1");
        issue(C_ACT, 2'd3, 12'h333); expect_err(1, "R2");
        issue(C_ACT, 2'd3, 12'h333); expect_err(0, "R2");
    endtask

    task automatic t_auto_pre;
        issue(C_RD, 2'd3, 12'h400); expect_err(0, "R8");
        idle(1);
        check(bank_busy_o[3], "R8", "busy after ap read", int'(bank_busy_o[3]), 1);
        idle(4);
        issue(C_ACT, 2'd3, 12'h044); expect_err(5, "R8");
        issue(C_ACT, 2'd3, 12'h044); expect_err(0, "R8");
        check(bank_open_o[3], "R8", "reopened", int'(bank_open_o[3]), 1);
    endtask

    task automatic t_refresh;
        issue(C_REF, 2'd0, 12'h000); expect_err(6, "R10");
        issue(C_PRE, 2'd3, 12'h000); expect_err(0, "R6");
        issue(C_REF, 2'd0, 12'h000); expect_err(6, "R10");
        idle(1);
        issue(C_REF, 2'd0, 12'h000); expect_err(0, "R10");
    endtask

    task automatic t_burst_stop;
        issue(C_ACT, 2'd0, 12'h010); expect_err(0, "R3");
        issue(C_RD, 2'd0, 12'h000); expect_err(0, "R11");
        issue(C_BST, 2'd0, 12'h000); expect_err(0, "R11");
        issue(C_BST, 2'd0, 12'h000); expect_err(7, "R11");
        issue(C_WR, 2'd0, 12'h000); expect_err(0, "R11");
        idle(3);
        issue(C_BST, 2'd0, 12'h000); expect_err(7, "R11");
    endtask

    task automatic t_full_page;
        issue(C_PRE, 2'd0, 12'h000); expect_err(0, "R6");
        idle(2);
        issue(C_MODE, 2'd0, 12'h007); expect_err(0, "R1");
        idle(1);
        issue(C_ACT, 2'd2, 12'h222); expect_err(0, "R3");
        issue(C_RD, 2'd2, 12'h400); expect_err(0, "R9");
        idle(10);
        check(bank_open_o[2] && !bank_busy_o[2], "R9", "full page keeps bank open",
              int'({bank_open_o[2], bank_busy_o[2]}), 2);
        issue(C_BST, 2'd0, 12'h000); expect_err(0, "R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_open_access();
        t_precharge();
        t_mode();
        t_auto_pre();
        t_refresh();
        t_burst_stop();
        t_full_page();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule